// File: doc/BRIEF.md
# Speculative Load Alias Table

This block keeps track of loads that were issued ahead of older stores whose addresses were not yet known. When such an early load issues, its destination register tag and the 8-byte memory block it read are written into a small fully associative table. Every store presents its address to all entries at once. Any valid entry whose block matches is cleared, because the early load may have read stale data.

When the program reaches the point where the load would have sat in program order, it asks the table about the same register tag. The answer is "pass" if a valid entry with that tag is still present, and the early value may be used. The answer is "fail" if the entry was cleared or was never there (evicted, flushed, or never inserted), and the core must then run its recovery code.

A clear-all input empties the table, for example on a context switch. When all eight entries are in use, a new load takes an entry in rotating order.

Top module: `spec_ld_table`

## Requirements
- R1: After reset every entry is invalid, both result outputs are low, and a check for any tag reports fail.
- R2: A check request for a tag whose entry is valid raises `chk_pass` for exactly one cycle, in the cycle after the request. The entry stays valid, so a repeated check passes again.
- R3: A check request for a tag with no valid entry raises `chk_fail` for exactly one cycle, in the cycle after the request.
- R4: A store whose address bits [31:3] equal those of a valid entry invalidates that entry, and a later check for its tag fails.
- R5: Address bits [2:0] take no part in matching. A store anywhere in the same 8-byte block kills the entry, and a store to a different block leaves it valid.
- R6: A single store invalidates every valid entry that matches its block, not only the first one.
- R7: Inserting a tag that is already held in a valid entry overwrites that entry with the new address. After that, only stores to the new block affect it.
- R8: An insert of a new tag goes to the lowest-numbered invalid entry. When all 8 entries are valid, the victim is chosen round-robin, starting at entry 0 after reset and advancing by one on each such replacement. The evicted tag then checks as fail.
- R9: When an insert and a matching store occur in the same cycle, the newly inserted entry is valid afterwards, and other entries matching the store are invalidated.
- R10: `clr_all` invalidates every entry at the next clock edge. An insert in the same cycle is dropped.
- R11: A check sees the table as it was before any store, insert or clear in the same cycle. A check together with a killing store therefore passes, and the next check fails.
- R12: `chk_pass` and `chk_fail` are never high together, and both are low in any cycle that follows a cycle without a check request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_all | input | 1 | Invalidate every entry |
| ins_vld | input | 1 | Early-load insert request |
| ins_tag | input | 5 | Destination register tag of the early load |
| ins_addr | input | 32 | Address read by the early load |
| st_vld | input | 1 | Store snoop request |
| st_addr | input | 32 | Store address |
| chk_vld | input | 1 | Check request |
| chk_tag | input | 5 | Register tag being checked |
| chk_pass | output | 1 | One-cycle pulse: speculation held |
| chk_fail | output | 1 | One-cycle pulse: recovery code needed |

## Verification
A table of single-operation steps inserts loads and then issues stores at several distances from them. The stores hit the exact address, land elsewhere in the same 8-byte block, or fall in the neighbouring block. This separates correct block-granular matching from exact-address or overly coarse matching. Other steps use two entries in one block and re-insert the same tag at a new address, which catches a store that kills only one entry and a duplicate entry left behind.

Directed cases then fire an operation together with a check, a store or a clear in the same cycle, to pin down which one takes precedence. A last case fills all eight entries and forces replacements, to show which entry is evicted.

// File: rtl/sldt_pkg.sv
package sldt_pkg;
  localparam int NUM_ENT  = 8;
  localparam int TAG_W    = 5;
  localparam int ADDR_W   = 32;
  localparam int BLK_LSB  = 3;
  localparam int BLK_W    = ADDR_W - BLK_LSB;
  localparam int IDX_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  typedef logic [TAG_W-1:0]   tag_t;
  typedef logic [BLK_W-1:0]   blk_t;
  typedef logic [NUM_ENT-1:0] ent_vec_t;
endpackage

// File: rtl/sldt_entry.sv
module sldt_entry
  import sldt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic wr_i,
  input  tag_t wr_tag_i,
  input  blk_t wr_blk_i,
  input  logic st_vld_i,
  input  blk_t st_blk_i,
  input  tag_t ins_tag_i,
  input  tag_t chk_tag_i,
  output logic vld_o,
  output logic ins_hit_o,
  output logic chk_hit_o
);
  logic vld_q, vld_d;
  tag_t tag_q;
  blk_t blk_q;
  logic st_hit;

  assign st_hit    = vld_q && st_vld_i && (blk_q == st_blk_i);
  assign ins_hit_o = vld_q && (tag_q == ins_tag_i);
  assign chk_hit_o = vld_q && (tag_q == chk_tag_i);
  assign vld_o     = vld_q;

  always_comb begin
    vld_d = vld_q;
    if (flush_i)     vld_d = 1'b0;
    else if (wr_i)   vld_d = 1'b1;
    else if (st_hit) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      blk_q <= '0;
    end else if (wr_i && !flush_i) begin
      tag_q <= wr_tag_i;
      blk_q <= wr_blk_i;
    end
  end

  assert_store_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !wr_i) |=> !vld_q);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !flush_i) |=> (vld_q && tag_q == $past(wr_tag_i) && blk_q == $past(wr_blk_i)));
endmodule

// File: rtl/sldt_alloc.sv
module sldt_alloc
  import sldt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ins_vld_i,
  input  logic     flush_i,
  input  ent_vec_t vld_vec_i,
  input  ent_vec_t hit_vec_i,
  output ent_vec_t sel_o
);
  logic [IDX_W-1:0] rr_q, rr_d;
  ent_vec_t free_sel, pick;
  logic     found, full, any_hit, do_ins, rr_use;

  assign full    = &vld_vec_i;
  assign any_hit = |hit_vec_i;
  assign do_ins  = ins_vld_i && !flush_i;
  assign rr_use  = do_ins && !any_hit && full;

  always_comb begin
    free_sel = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!vld_vec_i[i] && !found) begin
        free_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_hit)   pick = hit_vec_i;
    else if (full) pick = ent_vec_t'(1) << rr_q;
    else           pick = free_sel;
  end

  assign sel_o = do_ins ? pick : '0;

  always_comb begin
    rr_d = rr_q;
    if (rr_use) rr_d = (rr_q == IDX_W'(NUM_ENT-1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec_i));

  assert_insert_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_ins |-> $countones(sel_o) == 1);
endmodule

// File: rtl/sldt_result.sv
module sldt_result
  import sldt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chk_vld_i,
  input  ent_vec_t chk_hit_i,
  output logic     pass_o,
  output logic     fail_o
);
  logic pass_d, fail_d, pass_q, fail_q;

  always_comb begin
    pass_d = chk_vld_i &&  (|chk_hit_i);
    fail_d = chk_vld_i && !(|chk_hit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;

  assert_excl_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  assert_answer_given_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld_i |=> (pass_o || fail_o));

  assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_vld_i |=> (!pass_o && !fail_o));
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
  import sldt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              ins_vld,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_vld,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              chk_pass,
  output logic              chk_fail
);
  ent_vec_t vld_vec, ins_hit, chk_hit, wr_sel;
  blk_t     ins_blk, st_blk;

  assign ins_blk = ins_addr[ADDR_W-1:BLK_LSB];
  assign st_blk  = st_addr[ADDR_W-1:BLK_LSB];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    sldt_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (clr_all),
      .wr_i      (wr_sel[g]),
      .wr_tag_i  (ins_tag),
      .wr_blk_i  (ins_blk),
      .st_vld_i  (st_vld),
      .st_blk_i  (st_blk),
      .ins_tag_i (ins_tag),
      .chk_tag_i (chk_tag),
      .vld_o     (vld_vec[g]),
      .ins_hit_o (ins_hit[g]),
      .chk_hit_o (chk_hit[g])
    );
  end

  sldt_alloc u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_vld_i (ins_vld),
    .flush_i   (clr_all),
    .vld_vec_i (vld_vec),
    .hit_vec_i (ins_hit),
    .sel_o     (wr_sel)
  );

  sldt_result u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_vld_i (chk_vld),
    .chk_hit_i (chk_hit),
    .pass_o    (chk_pass),
    .fail_o    (chk_fail)
  );

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_vec == '0));

  assert_insert_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && !clr_all) |=> (vld_vec != '0));
endmodule

// File: tb/sim_spec_ld_table.sv
module sim_spec_ld_table;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_INS = 2'd0, OP_ST = 2'd1, OP_CHK = 2'd2, OP_CLR = 2'd3;
  localparam logic [1:0] EX_NONE = 2'b00, EX_PASS = 2'b01, EX_FAIL = 2'b10;
  localparam int NV = 22;
  // step = {op, tag, addr, expected {fail,pass} one cycle later}
  localparam logic [40:0] VTAB [NV] = '{
    {OP_CHK, 5'd3, 32'h0000_0000, EX_FAIL},  // R1 R3 nothing inserted
    {OP_INS, 5'd3, 32'h0000_1000, EX_NONE},
    {OP_CHK, 5'd3, 32'h0000_0000, EX_PASS},  // R2
    {OP_CHK, 5'd3, 32'h0000_0000, EX_PASS},  // R2 still valid
    {OP_ST,  5'd0, 32'h0000_2000, EX_NONE},
    {OP_CHK, 5'd3, 32'h0000_0000, EX_PASS},  // R5 other block
    {OP_ST,  5'd0, 32'h0000_1007, EX_NONE},
    {OP_CHK, 5'd3, 32'h0000_0000, EX_FAIL},  // R4 R5 same block
    {OP_INS, 5'd4, 32'h0000_3000, EX_NONE},
    {OP_INS, 5'd5, 32'h0000_3004, EX_NONE},
    {OP_ST,  5'd0, 32'h0000_3008, EX_NONE},
    {OP_CHK, 5'd4, 32'h0000_0000, EX_PASS},  // R5 neighbour block
    {OP_ST,  5'd0, 32'h0000_3003, EX_NONE},
    {OP_CHK, 5'd4, 32'h0000_0000, EX_FAIL},  // R6
    {OP_CHK, 5'd5, 32'h0000_0000, EX_FAIL},  // R6
    {OP_INS, 5'd6, 32'h0000_4000, EX_NONE},
    {OP_INS, 5'd6, 32'h0000_5000, EX_NONE},
    {OP_ST,  5'd0, 32'h0000_4000, EX_NONE},
    {OP_CHK, 5'd6, 32'h0000_0000, EX_PASS},  // R7 old address dropped
    {OP_ST,  5'd0, 32'h0000_5000, EX_NONE},
    {OP_CHK, 5'd6, 32'h0000_0000, EX_FAIL},  // R7 new address tracked
    {OP_CLR, 5'd0, 32'h0000_0000, EX_NONE}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic clr_all, ins_vld, st_vld, chk_vld;
  logic [4:0]  ins_tag, chk_tag;
  logic [31:0] ins_addr, st_addr;
  logic chk_pass, chk_fail;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_ld_table u0 (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .ins_vld(ins_vld), .ins_tag(ins_tag), .ins_addr(ins_addr),
    .st_vld(st_vld), .st_addr(st_addr),
    .chk_vld(chk_vld), .chk_tag(chk_tag),
    .chk_pass(chk_pass), .chk_fail(chk_fail)
  );

  task automatic idle();
    clr_all = 0; ins_vld = 0; st_vld = 0; chk_vld = 0;
    ins_tag = '0; chk_tag = '0; ins_addr = '0; st_addr = '0;
  endtask

  task automatic cyc(input logic iv, input logic [4:0] it, input logic [31:0] ia,
                     input logic sv, input logic [31:0] sa,
                     input logic cv, input logic [4:0] ct, input logic fl);
    ins_vld = iv; ins_tag = it; ins_addr = ia;
    st_vld = sv; st_addr = sa; chk_vld = cv; chk_tag = ct; clr_all = fl;
    @(negedge clk);
    idle();
  endtask

  task automatic expect_out(input logic [1:0] exp, input string req);
    total++;
    if ({chk_fail, chk_pass} !== exp) begin
      bad++;
      $display("FAIL %s: got fail/pass=%b expected %b", req, {chk_fail, chk_pass}, exp);
    end
  endtask

  task automatic check_tag(input logic [4:0] t, input logic [1:0] exp, input string req);
    cyc(0, '0, '0, 0, '0, 1, t, 0);
    expect_out(exp, req);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    expect_out(EX_NONE, "R1 outputs in reset");
    rst_n = 1;
    @(negedge clk);
    expect_out(EX_NONE, "R1 outputs after reset");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VTAB[i][40:39];
      cyc(op == OP_INS, VTAB[i][38:34], VTAB[i][33:2],
          op == OP_ST, VTAB[i][33:2],
          op == OP_CHK, VTAB[i][38:34], op == OP_CLR);
      expect_out(VTAB[i][1:0], $sformatf("R2-table step %0d", i));
    end

    // R11: check concurrent with killing store sees old state
    cyc(1, 5'd1, 32'h100, 0, '0, 0, '0, 0);
    cyc(0, '0, '0, 1, 32'h100, 1, 5'd1, 0);
    expect_out(EX_PASS, "R11 same-cycle check");
    check_tag(5'd1, EX_FAIL, "R11 next check");

    // R9: insert and matching store together
    cyc(1, 5'd2, 32'h200, 0, '0, 0, '0, 0);
    cyc(1, 5'd7, 32'h204, 1, 32'h200, 0, '0, 0);
    check_tag(5'd7, EX_PASS, "R9 new entry survives");
    check_tag(5'd2, EX_FAIL, "R9 old entry killed");

    // R10: clear all, insert in same cycle dropped
    cyc(1, 5'd8, 32'h300, 0, '0, 0, '0, 0);
    cyc(1, 5'd9, 32'h400, 0, '0, 0, '0, 1);
    expect_out(EX_NONE, "R12 no check no pulse");
    check_tag(5'd8, EX_FAIL, "R10 cleared");
    check_tag(5'd9, EX_FAIL, "R10 insert dropped");

    // R8: fill and replace round-robin
    do_reset();
    check_tag(5'd10, EX_FAIL, "R1 empty after reset");
    for (int k = 0; k < 8; k++) cyc(1, 5'(10 + k), 32'(k * 64), 0, '0, 0, '0, 0);
    for (int k = 0; k < 8; k++) check_tag(5'(10 + k), EX_PASS, "R8 filled");
    cyc(1, 5'd20, 32'h1000, 0, '0, 0, '0, 0);
    check_tag(5'd10, EX_FAIL, "R8 entry0 evicted");
    check_tag(5'd20, EX_PASS, "R8 new tag held");
    check_tag(5'd11, EX_PASS, "R8 entry1 kept");
    cyc(1, 5'd21, 32'h2000, 0, '0, 0, '0, 0);
    check_tag(5'd11, EX_FAIL, "R8 entry1 evicted");
    check_tag(5'd12, EX_PASS, "R8 entry2 kept");
    check_tag(5'd20, EX_PASS, "R8 earlier replacement kept");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule